// File: doc/BRIEF.md
# Register-Mapped Random Word Generator Controller

This block is a small random-word peripheral that software reaches through a 32-bit register bus. Software launches either a self-test or a seeding run by writing a command word. A sequencer runs the chosen operation for a fixed, parameterised number of cycles. When the operation finishes, a done flag is set and an interrupt can be raised. A seeding run can also end with a statistical failure. That failure is kept in an error register until software clears it, and the usual response is to reissue the seed command.

Once a seeding run has succeeded, a 16-word buffer fills from a deterministic linear-feedback shift register at one word per cycle. The shift register stands in for a real entropy source. Software drains the buffer one word per read of the data port and can watch the fill level in the status word. The done interrupt and the error interrupt are masked separately. The two clear commands follow different rules: one clears only the done flags, and only while no error is held. The other wipes the error register and the done flags together.

The sequencer has three states. SEQ_IDLE accepts a start. SEQ_TEST counts down the self-test. SEQ_SEED counts down a seeding run. The transitions are as follows:
- IDLE to TEST happens on a self-test command. This start wins if both start bits are written together.
- IDLE to SEED happens on a seed command.
- TEST to IDLE and SEED to IDLE happen when the counter reaches zero. At that point the finish pulse is raised.

Top module: `rnd_gen_ctrl`

## Requirements
- R1: After reset, the status (0x0C), error (0x10), command (0x04) and data port (0x14) registers read 0. The control register (0x08) reads 0x60, meaning both interrupts are masked, and irq is low.
- R2: Reads of the command register always return 0. Writes to the status, error and data port offsets change nothing.
- R3: Writing command bit 0 starts a self-test. Status bit 4 becomes 1 exactly TEST_CYCLES clock edges after the edge that accepted the write.
- R4: Writing command bit 1 starts a seeding run. Status bit 5 becomes 1 exactly SEED_CYCLES edges after acceptance. On success, the fill level in status bits 11:8 rises by one on each following edge, starting with the next one.
- R5: A start command that arrives while an operation is running is ignored. It neither changes when the running operation finishes nor starts a later one.
- R6: irq is high exactly when a done flag (status bit 4 or 5) is set while control bit 5 is 0, or when the error register is nonzero while control bit 6 is 0.
- R7: Command bit 4 clears both done flags only when the error register is zero. While an error is held it has no effect on the status, the error register or irq.
- R8: Command bit 5 clears the error register, status bit 16 and both done flags.
- R9: If the force_stat_err input is high on the edge that accepts a seed command, that run ends with error register 0x8 (bit 3), status bit 16 and status bit 5 set, and the buffer is not enabled.
- R10: Until a seeding run has succeeded, the fill level stays 0, and reads of the data port return 0 without removing anything.
- R11: Data port reads return words in generator order. The first word is LFSR_INIT, and each next word is (w >> 1) XOR (w[0] ? LFSR_POLY : 0). Each read removes one word. The level field shows 15 when all 16 entries are held.
- R12: If bits 0 and 1 are written together, only the self-test runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Combined, maskable interrupt |
| force_stat_err | input | 1 | Test input that forces a statistical failure on the seed run it accompanies |

## Verification
A write is accepted on the edge where it is presented, and read data reflects the state after the previous edge. A done flag therefore appears on the read issued TEST_CYCLES (or SEED_CYCLES) edges after the command edge, and the read one edge earlier must still see it clear. The bench counts edges exactly: every bus task consumes one edge, and idle gaps are sized so that a read lands on the last edge before a flag rises and on the first edge after it. Fill-level growth is checked on the reads immediately after seed completion, and irq is sampled mid-cycle right after each control or command write that could change it.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
    localparam int REG_W = 32;

    // register byte offsets (software decodes these)
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_ERR  = 8'h10;
    localparam logic [7:0] OFS_DATA = 8'h14;

    // command bits
    localparam int CMD_TEST   = 0;
    localparam int CMD_SEED   = 1;
    localparam int CMD_CLRINT = 4;
    localparam int CMD_CLRERR = 5;

    // control bits
    localparam int CTL_MDONE = 5;
    localparam int CTL_MERR  = 6;

    // status fields
    localparam int ST_TDONE  = 4;
    localparam int ST_SDONE  = 5;
    localparam int ST_LVL_LO = 8;
    localparam int ST_LVL_W  = 4;
    localparam int ST_ERR    = 16;

    // error register bit for a statistical failure
    localparam int ERR_STAT = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_TEST,
        SEQ_SEED
    } seq_state_t;
endpackage

// File: rtl/rngc_lfsr.sv
module rngc_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] POLY  = 32'hA300_0000,
    parameter logic [31:0] INIT  = 32'h1234_5678
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    // Galois form, shifting right
    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) state_d = state_d ^ POLY[WIDTH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= INIT[WIDTH-1:0];
        else if (step) state_q <= state_d;
    end

    assign value = state_q;
endmodule

// File: rtl/rngc_fifo.sv
module rngc_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head = mem[rd_ptr];

    logic unused_cnt_w;
    assign unused_cnt_w = (CNT_W == 0);
endmodule

// File: rtl/rngc_seq.sv
module rngc_seq
    import rngc_pkg::*;
#(
    parameter int TEST_CYCLES = 12,
    parameter int SEED_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_test,
    input  logic go_seed,
    input  logic inject_err,
    output logic busy,
    output logic test_fin,
    output logic seed_ok,
    output logic seed_bad
);
    localparam int MAXC  = (TEST_CYCLES > SEED_CYCLES) ? TEST_CYCLES : SEED_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             bad_q, bad_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bad_q   <= bad_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bad_d   = bad_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go_test) begin
                    state_d = SEQ_TEST;
                    cnt_d   = CNT_W'(TEST_CYCLES - 1);
                end else if (go_seed) begin
                    state_d = SEQ_SEED;
                    cnt_d   = CNT_W'(SEED_CYCLES - 1);
                    bad_d   = inject_err;
                end
            end
            SEQ_TEST, SEQ_SEED: begin
                if (cnt_q == '0) state_d = SEQ_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != SEQ_IDLE);
        test_fin = (state_q == SEQ_TEST) && (cnt_q == '0);
        seed_ok  = (state_q == SEQ_SEED) && (cnt_q == '0) && !bad_q;
        seed_bad = (state_q == SEQ_SEED) && (cnt_q == '0) &&  bad_q;
    end
endmodule

// File: rtl/rnd_gen_ctrl.sv
module rnd_gen_ctrl
    import rngc_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          WORD_W      = 32,
    parameter int          FIFO_DEPTH  = 16,
    parameter int          TEST_CYCLES = 12,
    parameter int          SEED_CYCLES = 20,
    parameter logic [31:0] LFSR_POLY   = 32'hA300_0000,
    parameter logic [31:0] LFSR_INIT   = 32'h1234_5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    input  logic              force_stat_err
);
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam int LVL_MAX = (1 << ST_LVL_W) - 1;

    logic wr_en, hit_cmd, hit_ctrl, hit_stat, hit_err, hit_data;
    logic cmd_wr, go_test, go_seed, clr_int_ok, clr_err;
    logic busy, test_fin, seed_ok, seed_bad;
    logic mask_done, mask_err;
    logic tdone_q, sdone_q, seeded_q;
    logic [REG_W-1:0]  err_q;
    logic [WORD_W-1:0] gen_word, fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [ST_LVL_W-1:0] lvl;
    logic fifo_push, fifo_pop;

    // decode
    assign wr_en    = bus_sel && bus_wr;
    assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign hit_err  = (bus_addr == ADDR_W'(OFS_ERR));
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));

    assign cmd_wr     = wr_en && hit_cmd;
    assign go_test    = cmd_wr && bus_wdata[CMD_TEST];
    assign go_seed    = cmd_wr && bus_wdata[CMD_SEED];
    assign clr_err    = cmd_wr && bus_wdata[CMD_CLRERR];
    assign clr_int_ok = cmd_wr && bus_wdata[CMD_CLRINT] && (err_q == '0);

    rngc_seq #(
        .TEST_CYCLES (TEST_CYCLES),
        .SEED_CYCLES (SEED_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_test    (go_test),
        .go_seed    (go_seed),
        .inject_err (force_stat_err),
        .busy       (busy),
        .test_fin   (test_fin),
        .seed_ok    (seed_ok),
        .seed_bad   (seed_bad)
    );

    // control register: interrupt masks, both set out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_done <= 1'b1;
            mask_err  <= 1'b1;
        end else if (wr_en && hit_ctrl) begin
            mask_done <= bus_wdata[CTL_MDONE];
            mask_err  <= bus_wdata[CTL_MERR];
        end
    end

    // completion and error flags; a finishing event wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdone_q  <= 1'b0;
            sdone_q  <= 1'b0;
            seeded_q <= 1'b0;
            err_q    <= '0;
        end else begin
            if (clr_err || clr_int_ok) begin
                tdone_q <= 1'b0;
                sdone_q <= 1'b0;
            end
            if (clr_err)              err_q           <= '0;
            if (test_fin)             tdone_q         <= 1'b1;
            if (seed_ok || seed_bad)  sdone_q         <= 1'b1;
            if (seed_bad)             err_q[ERR_STAT] <= 1'b1;
            if (seed_ok)              seeded_q        <= 1'b1;
        end
    end

    // word buffer fed by the generator
    assign fifo_pop  = bus_sel && !bus_wr && hit_data && (fifo_cnt != '0);
    assign fifo_push = seeded_q && ((fifo_cnt < CNT_W'(FIFO_DEPTH)) || fifo_pop);

    rngc_lfsr #(
        .WIDTH (WORD_W),
        .POLY  (LFSR_POLY),
        .INIT  (LFSR_INIT)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fifo_push),
        .value (gen_word)
    );

    rngc_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (gen_word),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_cnt)
    );

    assign lvl = (fifo_cnt > CNT_W'(LVL_MAX)) ? ST_LVL_W'(LVL_MAX) : ST_LVL_W'(fifo_cnt);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[CTL_MDONE] = mask_done;
            bus_rdata[CTL_MERR]  = mask_err;
        end else if (hit_stat) begin
            bus_rdata[ST_TDONE]                     = tdone_q;
            bus_rdata[ST_SDONE]                     = sdone_q;
            bus_rdata[ST_LVL_LO +: ST_LVL_W]        = lvl;
            bus_rdata[ST_ERR]                       = (err_q != '0);
        end else if (hit_err) begin
            bus_rdata = err_q;
        end else if (hit_data && fifo_cnt != '0) begin
            bus_rdata = REG_W'(fifo_head);
        end
    end

    assign irq = ((tdone_q || sdone_q) && !mask_done) || ((err_q != '0) && !mask_err);

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata, busy};
endmodule

module rnd_gen_ctrl_chk
    import rngc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              irq,
    input logic [REG_W-1:0]  err_q,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              seeded_q,
    input logic              busy,
    input logic              fin,
    input logic              seed_bad,
    input logic              mask_done,
    input logic              mask_err
);
    logic cmd_w;
    assign cmd_w = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_CMD)) |-> (bus_rdata == '0)); // R2

    AST_BUSY_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin && cmd_w && (bus_wdata[CMD_TEST] || bus_wdata[CMD_SEED])) |=> busy); // R5

    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_done && mask_err) |-> !irq); // R6

    AST_CLRINT_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[CMD_CLRINT] && !bus_wdata[CMD_CLRERR] && err_q != '0)
        |=> (err_q == $past(err_q))); // R7

    AST_CLRERR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[CMD_CLRERR] && !seed_bad) |=> (err_q == '0)); // R8

    AST_NO_FILL_UNSEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        !seeded_q |-> (fifo_cnt == '0)); // R10

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_DATA) && fifo_cnt == '0)
        |-> (bus_rdata == '0)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R11
endmodule

bind rnd_gen_ctrl rnd_gen_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .err_q     (err_q),
    .fifo_cnt  (fifo_cnt),
    .seeded_q  (seeded_q),
    .busy      (busy),
    .fin       (test_fin || seed_ok || seed_bad),
    .seed_bad  (seed_bad),
    .mask_done (mask_done),
    .mask_err  (mask_err)
);

// File: tb/rnd_gen_ctrl_tb.sv
module rnd_gen_ctrl_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          TCYC       = 12;
    localparam int          SCYC       = 20;
    localparam logic [31:0] POLY       = 32'hA300_0000;
    localparam logic [31:0] INIT       = 32'h1234_5678;

    localparam logic [7:0] A_CMD  = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_ERR  = 8'h10;
    localparam logic [7:0] A_DATA = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, force_err = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    logic [31:0] msk_q [$];
    string       tag_q [$];
    event        smp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_gen_ctrl #(
        .TEST_CYCLES (TCYC),
        .SEED_CYCLES (SCYC),
        .LFSR_POLY   (POLY),
        .LFSR_INIT   (INIT)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel        (sel),
        .bus_wr         (wr),
        .bus_addr       (addr),
        .bus_wdata      (wdata),
        .bus_rdata      (rdata),
        .irq            (irq),
        .force_stat_err (force_err)
    );

    function automatic logic [31:0] gen_next(input logic [31:0] w);
        return (w >> 1) ^ (w[0] ? POLY : 32'h0);
    endfunction

    // monitor: pops one expected item per sampled read
    initial forever begin
        @(smp_ev);
        begin
            logic [31:0] e, m;
            string t;
            e = exp_q.pop_front();
            m = msk_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if ((rdata & m) !== (e & m)) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h (mask %h)", t, rdata & m, e & m, m);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    // driver: pushes the expected value, then lets the monitor sample
    task automatic bus_read(input logic [7:0] a, input logic [31:0] e,
                            input logic [31:0] m, input string t);
        sel = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(e);
        msk_q.push_back(m);
        tag_q.push_back(t);
        #2;
        -> smp_ev;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(A_STAT, 32'h0, 32'hFFFF_FFFF, "R1 status after reset");
        bus_read(A_ERR,  32'h0, 32'hFFFF_FFFF, "R1 error after reset");
        bus_read(A_CTRL, 32'h60, 32'hFFFF_FFFF, "R1 control after reset");
        bus_read(A_CMD,  32'h0, 32'hFFFF_FFFF, "R1 command after reset");
        chk_irq(1'b0, "R1 irq after reset");
        bus_read(A_DATA, 32'h0, 32'hFFFF_FFFF, "R10 data port before seeding");

        // R6 unmask both sources
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, 32'h0, 32'hFFFF_FFFF, "R6 control unmasked");

        // R3 self-test timing
        bus_write(A_CMD, 32'h1);
        idle(TCYC - 1);
        bus_read(A_STAT, 32'h0,  32'hFFFF_FFFF, "R3 test not yet done");
        bus_read(A_STAT, 32'h10, 32'hFFFF_FFFF, "R3 test done");
        chk_irq(1'b1, "R6 done irq unmasked");
        bus_write(A_CTRL, 32'h20);
        chk_irq(1'b0, "R6 done irq masked");
        bus_write(A_CTRL, 32'h0);
        chk_irq(1'b1, "R6 done irq unmasked again");
        bus_write(A_CMD, 32'h10);
        bus_read(A_STAT, 32'h0, 32'hFFFF_FFFF, "R7 clear-int with no error");
        chk_irq(1'b0, "R7 irq after clear-int");

        // R12 both start bits: self-test only
        bus_write(A_CMD, 32'h3);
        idle(TCYC - 1);
        bus_read(A_STAT, 32'h0,  32'h30, "R12 not yet done");
        bus_read(A_STAT, 32'h10, 32'hFFFF_FFFF, "R12 self-test done");
        idle(SCYC + 4);
        bus_read(A_STAT, 32'h10, 32'hFFFF_FFFF, "R12 no seed run");
        bus_write(A_CMD, 32'h10);

        // R9 forced statistical failure
        force_err = 1'b1;
        bus_write(A_CMD, 32'h2);
        force_err = 1'b0;
        idle(SCYC - 1);
        bus_read(A_STAT, 32'h0, 32'hFFFF_FFFF, "R9 seed not yet done");
        bus_read(A_STAT, 32'h0001_0020, 32'hFFFF_FFFF, "R9 seed done with error");
        bus_read(A_ERR,  32'h8, 32'hFFFF_FFFF, "R9 error register");
        chk_irq(1'b1, "R9 irq on error");
        idle(4);
        bus_read(A_STAT, 32'h0, 32'h0F00, "R10 level stays 0 after failed seed");
        bus_read(A_DATA, 32'h0, 32'hFFFF_FFFF, "R10 data port after failed seed");

        // R7 clear-int ignored while error held
        bus_write(A_CMD, 32'h10);
        bus_read(A_STAT, 32'h0001_0020, 32'hFFFF_FFFF, "R7 clear-int blocked by error");
        bus_read(A_ERR,  32'h8, 32'hFFFF_FFFF, "R7 error kept");
        chk_irq(1'b1, "R7 irq kept");
        bus_write(A_CTRL, 32'h40);
        chk_irq(1'b1, "R6 error masked, done still raises");
        bus_write(A_CTRL, 32'h60);
        chk_irq(1'b0, "R6 both masked");
        bus_write(A_CTRL, 32'h0);

        // R8 clear-error
        bus_write(A_CMD, 32'h20);
        bus_read(A_STAT, 32'h0, 32'hFFFF_FFFF, "R8 status after clear-error");
        bus_read(A_ERR,  32'h0, 32'hFFFF_FFFF, "R8 error after clear-error");
        chk_irq(1'b0, "R8 irq after clear-error");

        // R2 writes to read-only offsets do nothing
        bus_write(A_ERR,  32'hFFFF_FFFF);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_write(A_DATA, 32'hFFFF_FFFF);
        bus_read(A_ERR,  32'h0, 32'hFFFF_FFFF, "R2 error unwritable");
        bus_read(A_STAT, 32'h0, 32'hFFFF_FFFF, "R2 status unwritable");
        bus_read(A_DATA, 32'h0, 32'hFFFF_FFFF, "R2 data port unwritable");

        // R4 / R5 seed with an ignored start while busy
        bus_write(A_CMD, 32'h2);
        idle(2);
        bus_write(A_CMD, 32'h1);
        idle(SCYC - 4);
        bus_read(A_STAT, 32'h0,   32'h30, "R5 seed finish not moved");
        bus_read(A_STAT, 32'h20,  32'hFFFF_FFFF, "R4 seed done, level 0");
        bus_read(A_STAT, 32'h120, 32'hFFFF_FFFF, "R4 level 1");
        bus_read(A_STAT, 32'h220, 32'hFFFF_FFFF, "R4 level 2");
        idle(TCYC + 20);
        bus_read(A_STAT, 32'h0, 32'h10, "R5 ignored self-test never ran");
        bus_read(A_STAT, 32'h0F00, 32'h0F00, "R11 level saturates at 15");

        // R11 words in generator order
        w = INIT;
        for (int k = 0; k < 20; k++) begin
            bus_read(A_DATA, w, 32'hFFFF_FFFF, $sformatf("R11 word %0d", k));
            w = gen_next(w);
        end

        bus_write(A_CMD, 32'h10);
        chk_irq(1'b0, "R7 final clear-int");
        bus_read(A_CMD, 32'h0, 32'hFFFF_FFFF, "R2 command reads zero");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule